// File: doc/BRIEF.md
# Mailbox Pointer Controller for Command and Response Buffers

This block is the byte-level mailbox behind a serial memory-style host port. The host issues single-byte requests carrying an address, a write flag and data. Writes landing in the buffer window fill a command buffer through a self-advancing command pointer. Reads from the same window drain a response buffer through a separate self-advancing response pointer. Writes to a small reset window return both pointers to zero without touching the stored response.

A processor-side stub reads the command bytes through a plain index port. It is told by a one-cycle pulse when a complete command block has arrived. It writes response bytes into the response buffer and then commits the response with its length and two error flags. An 8-bit status byte combines three live inputs with the checksum-error, response-present and execution-error flags.

Host requests use a valid/ready channel. A request is taken on a cycle where `req_valid` and `req_ready` are both high. Every accepted read produces one byte on a registered valid/ready response channel. `req_ready` drops while a response is held and `rsp_ready` is low, so at most one response is ever outstanding. A held response keeps its data stable until it is taken. Writes produce no response.

Top module: `mbox_ptr_ctrl`

## Requirements
- R1: A request is taken only when `req_valid` and `req_ready` are both high. `req_ready` is low exactly while `rsp_valid` is high and `rsp_ready` is low. A read's byte appears on `rsp_data` with `rsp_valid` in the cycle after acceptance, and stays unchanged until `rsp_ready` is high.
- R2: A write to any address from 0xFE00 to 0xFE3F stores its byte at the command pointer and then advances the pointer by one. The address offset inside the window has no effect, and the stored byte is visible on `cmd_rd_byte` at index `cmd_rd_idx`.
- R3: The byte stored at command index 0 is the block length, and it counts itself. The write that brings the command pointer up to that length is the completing write. `cmd_done` is high for exactly one cycle, in the cycle after the completing write. After that, further command writes (such as 0xFF padding) are dropped until the command pointer is reset.
- R4: The command pointer stops at 64. Writes arriving with a full buffer are dropped, and nothing beyond index 63 is overwritten.
- R5: Every write to the buffer window resets the response pointer to 0.
- R6: A read from the buffer window returns the response byte at the response pointer and advances the pointer by one, stopping at 64. A position at or beyond the committed length returns 0xFF.
- R7: A read from the buffer window resets the command pointer to 0 and reopens the command buffer, so the next command write becomes a new length byte at index 0. The read leaves the status byte and the contents of both buffers unchanged.
- R8: A write with any data to any address from 0xFFE0 to 0xFFFF resets both pointers to 0 and empties the command buffer. It clears status bit 4 and leaves every other status bit and the response contents unchanged.
- R9: A cycle with `pr_commit` high sets status bit 6. In the same cycle it loads bit 4 from `pr_crc_err`, loads bit 7 from `pr_exec_err`, and latches `pr_len` (capped at 64) as the response length.
- R10: The status byte takes bit 0 from `st_busy`, bit 1 from `st_wen` and bit 2 from `st_wake_n`. Bits 3 and 5 are always 0. After reset, bits 4, 6 and 7 are 0.
- R11: Reads from addresses outside both windows return 0xFF. Writes to them change no pointer, no buffer and no status bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Host request can be taken |
| req_we | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write byte |
| rsp_valid | output | 1 | Read byte valid |
| rsp_ready | input | 1 | Host takes the read byte |
| rsp_data | output | 8 | Read byte |
| cmd_done | output | 1 | One-cycle pulse: command block complete |
| cmd_rd_idx | input | 6 | Processor read index into command buffer |
| cmd_rd_byte | output | 8 | Command byte at `cmd_rd_idx` |
| pr_wr_en | input | 1 | Processor writes a response byte |
| pr_wr_idx | input | 6 | Response byte index |
| pr_wr_byte | input | 8 | Response byte |
| pr_commit | input | 1 | Commit new response |
| pr_len | input | 7 | Committed response length |
| pr_crc_err | input | 1 | Checksum error of the processed command |
| pr_exec_err | input | 1 | Execution error of the processed command |
| st_busy | input | 1 | Busy flag, status bit 0 |
| st_wen | input | 1 | Write-enable flag, status bit 1 |
| st_wake_n | input | 1 | Low-power flag, active low, status bit 2 |
| status | output | 8 | Status byte |

## Verification
Directed blocks are the first set of input patterns. They include a short command followed by padding, which separates completion from the saturation of R4. They include reads past a short response, which separates the committed length from the buffer size, and alternating reads and writes, which show that each access resets the other buffer's pointer. Reset-window writes carry nonzero data and are issued with every status flag set, so a design that clears more than the checksum flag shows up. A stalled response channel with a second request waiting shows whether back-pressure holds the data and delays acceptance. Finally, a seeded random mix of window writes, window reads, reset writes, stray accesses and response loads runs against a bench model, to catch pointer interactions in orders that no directed block covers.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef enum logic [1:0] {
    RGN_NONE = 2'd0,
    RGN_BUF  = 2'd1,
    RGN_RST  = 2'd2
  } region_e;

  localparam int ST_BUSY = 0;
  localparam int ST_WEN  = 1;
  localparam int ST_WAKE = 2;
  localparam int ST_CRCE = 4;
  localparam int ST_RRDY = 6;
  localparam int ST_EERR = 7;

  localparam logic [7:0] FILL_BYTE = 8'hFF;
endpackage

// File: rtl/mbx_decode.sv
module mbx_decode
  import mbx_pkg::*;
#(
  parameter int AW       = 16,
  parameter int BUF_BASE = 'hFE00,
  parameter int DEPTH    = 64,
  parameter int RST_BASE = 'hFFE0,
  parameter int RST_SPAN = 32
) (
  input  logic [AW-1:0] addr,
  output region_e       region
);
  localparam logic [AW-1:0] BUF_LO = AW'(BUF_BASE);
  localparam logic [AW-1:0] BUF_HI = AW'(BUF_BASE + DEPTH - 1);
  localparam logic [AW-1:0] RST_LO = AW'(RST_BASE);
  localparam logic [AW-1:0] RST_HI = AW'(RST_BASE + RST_SPAN - 1);

  always_comb begin
    if (addr >= BUF_LO && addr <= BUF_HI)      region = RGN_BUF;
    else if (addr >= RST_LO && addr <= RST_HI) region = RGN_RST;
    else                                       region = RGN_NONE;
  end
endmodule

// File: rtl/mbx_cmd_buf.sv
module mbx_cmd_buf #(
  parameter int DEPTH = 64,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr,
  input  logic [7:0]       wdata,
  input  logic             clr,
  input  logic [PW-2:0]    rd_idx,
  output logic [7:0]       rd_byte,
  output logic [PW-1:0]    ptr,
  output logic             done
);
  logic [7:0]    mem [DEPTH];
  logic [7:0]    len_q;
  logic [PW-1:0] ptr_q;
  logic          full_blk_q;
  logic          done_q;
  logic          take;
  logic [7:0]    eff_len;
  logic          finishing;

  assign take      = wr && !full_blk_q && (int'(ptr_q) < DEPTH);
  assign eff_len   = (ptr_q == '0) ? wdata : len_q;
  assign finishing = take && ((int'(ptr_q) + 1) >= int'(eff_len));

  always_ff @(posedge clk) begin
    if (take) mem[ptr_q[PW-2:0]] <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q      <= '0;
      len_q      <= '0;
      full_blk_q <= 1'b0;
      done_q     <= 1'b0;
    end else begin
      done_q <= finishing;
      if (clr) begin
        ptr_q      <= '0;
        len_q      <= '0;
        full_blk_q <= 1'b0;
      end else if (take) begin
        ptr_q <= ptr_q + 1'b1;
        if (ptr_q == '0) len_q <= wdata;
        if (finishing) full_blk_q <= 1'b1;
      end
    end
  end

  assign rd_byte = mem[rd_idx];
  assign ptr     = ptr_q;
  assign done    = done_q;

  AST_CMD_PTR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) <= DEPTH); // R4
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q); // R3
  AST_DROP_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (full_blk_q && wr && !clr) |=> $stable(ptr_q)); // R3
  AST_CMD_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ptr_q == '0) && !full_blk_q); // R7
endmodule

// File: rtl/mbx_rsp_buf.sv
module mbx_rsp_buf
  import mbx_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int PW    = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ld_wr,
  input  logic [PW-2:0] ld_idx,
  input  logic [7:0]    ld_byte,
  input  logic          commit,
  input  logic [PW-1:0] commit_len,
  input  logic          rd,
  input  logic          clr,
  output logic [7:0]    rd_byte,
  output logic          in_range
);
  logic [7:0]    mem [DEPTH];
  logic [PW-1:0] ptr_q;
  logic [PW-1:0] len_q;
  logic [PW-1:0] len_cap;

  assign len_cap  = (int'(commit_len) > DEPTH) ? PW'(DEPTH) : commit_len;
  assign in_range = ptr_q < len_q;
  assign rd_byte  = in_range ? mem[ptr_q[PW-2:0]] : FILL_BYTE;

  always_ff @(posedge clk) begin
    if (ld_wr) mem[ld_idx] <= ld_byte;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ptr_q <= '0;
      len_q <= '0;
    end else begin
      if (commit) len_q <= len_cap;
      if (clr) ptr_q <= '0;
      else if (rd && int'(ptr_q) < DEPTH) ptr_q <= ptr_q + 1'b1;
    end
  end

  AST_RSP_PTR_SAT: assert property (@(posedge clk) disable iff (!rst_n)
    int'(ptr_q) <= DEPTH); // R6
  AST_RSP_CLR: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> ptr_q == '0); // R5
  AST_RSP_ADV: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && !clr && int'(ptr_q) < DEPTH) |=> ptr_q == $past(ptr_q) + 1'b1); // R6
endmodule

// File: rtl/mbx_status.sv
module mbx_status
  import mbx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       commit,
  input  logic       crc_err,
  input  logic       exec_err,
  input  logic       clr_crc,
  input  logic       busy,
  input  logic       wen,
  input  logic       wake_n,
  output logic [7:0] status
);
  logic crce_q, rrdy_q, eerr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      crce_q <= 1'b0;
      rrdy_q <= 1'b0;
      eerr_q <= 1'b0;
    end else if (commit) begin
      crce_q <= crc_err;
      rrdy_q <= 1'b1;
      eerr_q <= exec_err;
    end else if (clr_crc) begin
      crce_q <= 1'b0;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_BUSY] = busy;
    status[ST_WEN]  = wen;
    status[ST_WAKE] = wake_n;
    status[ST_CRCE] = crce_q;
    status[ST_RRDY] = rrdy_q;
    status[ST_EERR] = eerr_q;
  end

  AST_CRCE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_crc && !commit) |=> !status[ST_CRCE]); // R8
  AST_KEEP_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_crc && !commit) |=> $stable(status[ST_RRDY]) && $stable(status[ST_EERR])); // R8
  AST_RRDY_SET: assert property (@(posedge clk) disable iff (!rst_n)
    commit |=> status[ST_RRDY]); // R9
endmodule

// File: rtl/mbox_ptr_ctrl.sv
module mbox_ptr_ctrl
  import mbx_pkg::*;
#(
  parameter int AW       = 16,
  parameter int DEPTH    = 64,
  parameter int BUF_BASE = 'hFE00,
  parameter int RST_BASE = 'hFFE0,
  parameter int RST_SPAN = 32,
  localparam int PW      = $clog2(DEPTH) + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_we,
  input  logic [AW-1:0] req_addr,
  input  logic [7:0]    req_wdata,
  output logic          rsp_valid,
  input  logic          rsp_ready,
  output logic [7:0]    rsp_data,
  output logic          cmd_done,
  input  logic [PW-2:0] cmd_rd_idx,
  output logic [7:0]    cmd_rd_byte,
  input  logic          pr_wr_en,
  input  logic [PW-2:0] pr_wr_idx,
  input  logic [7:0]    pr_wr_byte,
  input  logic          pr_commit,
  input  logic [PW-1:0] pr_len,
  input  logic          pr_crc_err,
  input  logic          pr_exec_err,
  input  logic          st_busy,
  input  logic          st_wen,
  input  logic          st_wake_n,
  output logic [7:0]    status
);
  region_e       region;
  logic          acc;
  logic          buf_wr, buf_rd, rst_wr, stray_rd;
  logic          rsp_valid_q;
  logic [7:0]    rsp_data_q;
  logic [7:0]    rsp_byte;
  logic          rsp_in_range;
  logic [PW-1:0] cmd_ptr;

  mbx_decode #(
    .AW(AW), .BUF_BASE(BUF_BASE), .DEPTH(DEPTH),
    .RST_BASE(RST_BASE), .RST_SPAN(RST_SPAN)
  ) u_decode (
    .addr  (req_addr),
    .region(region)
  );

  assign req_ready = !rsp_valid_q || rsp_ready;
  assign acc       = req_valid && req_ready;
  assign buf_wr    = acc &&  req_we && (region == RGN_BUF);
  assign buf_rd    = acc && !req_we && (region == RGN_BUF);
  assign rst_wr    = acc &&  req_we && (region == RGN_RST);
  assign stray_rd  = acc && !req_we && (region == RGN_NONE);

  mbx_cmd_buf #(.DEPTH(DEPTH), .PW(PW)) u_cmd (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr     (buf_wr),
    .wdata  (req_wdata),
    .clr    (rst_wr || buf_rd),
    .rd_idx (cmd_rd_idx),
    .rd_byte(cmd_rd_byte),
    .ptr    (cmd_ptr),
    .done   (cmd_done)
  );

  mbx_rsp_buf #(.DEPTH(DEPTH), .PW(PW)) u_rsp (
    .clk       (clk),
    .rst_n     (rst_n),
    .ld_wr     (pr_wr_en),
    .ld_idx    (pr_wr_idx),
    .ld_byte   (pr_wr_byte),
    .commit    (pr_commit),
    .commit_len(pr_len),
    .rd        (buf_rd),
    .clr       (rst_wr || buf_wr),
    .rd_byte   (rsp_byte),
    .in_range  (rsp_in_range)
  );

  mbx_status u_status (
    .clk     (clk),
    .rst_n   (rst_n),
    .commit  (pr_commit),
    .crc_err (pr_crc_err),
    .exec_err(pr_exec_err),
    .clr_crc (rst_wr),
    .busy    (st_busy),
    .wen     (st_wen),
    .wake_n  (st_wake_n),
    .status  (status)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid_q <= 1'b0;
      rsp_data_q  <= '0;
    end else if (acc && !req_we) begin
      rsp_valid_q <= 1'b1;
      rsp_data_q  <= buf_rd ? rsp_byte : FILL_BYTE;
    end else if (rsp_ready) begin
      rsp_valid_q <= 1'b0;
    end
  end

  assign rsp_valid = rsp_valid_q;
  assign rsp_data  = rsp_data_q;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid_q && !rsp_ready) |=> rsp_valid_q && $stable(rsp_data_q)); // R1
  AST_STRAY_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    stray_rd |=> rsp_data_q == FILL_BYTE); // R11
  AST_PAST_END_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_rd && !rsp_in_range) |=> rsp_data_q == FILL_BYTE); // R6
  AST_STRAY_WR_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_we && region == RGN_NONE) |=> $stable(cmd_ptr)); // R11
endmodule

// File: tb/mbox_ptr_ctrl_tb.sv
`timescale 1ns/1ps
module mbox_ptr_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 0, req_we = 0, rsp_ready = 1;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid, cmd_done;
  logic [7:0]  rsp_data, cmd_rd_byte, status;
  logic [5:0]  cmd_rd_idx = '0, pr_wr_idx = '0;
  logic        pr_wr_en = 0, pr_commit = 0, pr_crc_err = 0, pr_exec_err = 0;
  logic [7:0]  pr_wr_byte = '0;
  logic [6:0]  pr_len = '0;
  logic        st_busy = 0, st_wen = 0, st_wake_n = 0;

  always #2.5 clk = ~clk;

  mbox_ptr_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_we(req_we), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data),
    .cmd_done(cmd_done), .cmd_rd_idx(cmd_rd_idx), .cmd_rd_byte(cmd_rd_byte),
    .pr_wr_en(pr_wr_en), .pr_wr_idx(pr_wr_idx), .pr_wr_byte(pr_wr_byte),
    .pr_commit(pr_commit), .pr_len(pr_len), .pr_crc_err(pr_crc_err),
    .pr_exec_err(pr_exec_err), .st_busy(st_busy), .st_wen(st_wen),
    .st_wake_n(st_wake_n), .status(status)
  );

  int n_chk = 0, n_bad = 0, seen_done = 0, exp_done = 0;
  bit finished = 0;

  logic [7:0] m_cmd [64];
  logic [7:0] m_rsp [64];
  int m_cptr = 0, m_clen = 0, m_rptr = 0, m_rlen = 0;
  bit m_ccomp = 0, m_crce = 0, m_rrdy = 0, m_eerr = 0;

  always @(posedge clk) if (rst_n && cmd_done) seen_done++;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int region_of(input logic [15:0] a);
    if (a >= 16'hFE00 && a <= 16'hFE3F) return 1;
    if (a >= 16'hFFE0) return 2;
    return 0;
  endfunction

  function automatic logic [7:0] exp_status();
    return {m_eerr, m_rrdy, 1'b0, m_crce, 1'b0, st_wake_n, st_wen, st_busy};
  endfunction

  function automatic void model_write(input logic [15:0] a, input logic [7:0] d);
    int r = region_of(a);
    if (r == 1) begin
      m_rptr = 0;
      if (!m_ccomp && m_cptr < 64) begin
        m_cmd[m_cptr] = d;
        if (m_cptr == 0) m_clen = d;
        m_cptr++;
        if (m_cptr >= m_clen) begin m_ccomp = 1; exp_done++; end
      end
    end else if (r == 2) begin
      m_cptr = 0; m_ccomp = 0; m_clen = 0; m_rptr = 0; m_crce = 0;
    end
  endfunction

  function automatic logic [7:0] model_read(input logic [15:0] a);
    logic [7:0] v = 8'hFF;
    if (region_of(a) == 1) begin
      if (m_rptr < m_rlen) v = m_rsp[m_rptr];
      if (m_rptr < 64) m_rptr++;
      m_cptr = 0; m_ccomp = 0; m_clen = 0;
    end
    return v;
  endfunction

  task automatic bus_op(input bit we, input logic [15:0] a, input logic [7:0] d,
                        output logic [7:0] rd);
    bit took;
    @(negedge clk);
    req_valid = 1; req_we = we; req_addr = a; req_wdata = d;
    forever begin
      #1 took = req_ready;
      @(posedge clk);
      if (took) break;
      @(negedge clk);
    end
    @(negedge clk);
    req_valid = 0;
    rd = rsp_data;
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    logic [7:0] x;
    bus_op(1, a, d, x);
    model_write(a, d);
  endtask

  task automatic rd_chk(input logic [15:0] a, input string req);
    logic [7:0] x, e;
    e = model_read(a);
    bus_op(0, a, 8'h00, x);
    chk(rsp_valid === 1'b1 && x === e, req, x, e);
  endtask

  task automatic load_resp(input int len, input bit ce, input bit ee);
    for (int i = 0; i < len && i < 64; i++) begin
      @(negedge clk);
      pr_wr_en = 1; pr_wr_idx = 6'(i); pr_wr_byte = 8'($urandom);
      m_rsp[i] = pr_wr_byte;
    end
    @(negedge clk);
    pr_wr_en = 0; pr_commit = 1; pr_len = 7'(len); pr_crc_err = ce; pr_exec_err = ee;
    @(negedge clk);
    pr_commit = 0;
    m_rlen = (len > 64) ? 64 : len; m_rrdy = 1; m_crce = ce; m_eerr = ee;
  endtask

  task automatic chk_status(input string req);
    @(negedge clk); #1;
    chk(status === exp_status(), req, status, exp_status());
  endtask

  task automatic chk_cmd(input int idx, input string req);
    @(negedge clk);
    cmd_rd_idx = 6'(idx); #1;
    chk(cmd_rd_byte === m_cmd[idx], req, cmd_rd_byte, m_cmd[idx]);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=finish");
    summary();
  end

  initial begin
    logic [7:0] x, e1, e2;
    void'($urandom(32'h5EED_1234));
    repeat (3) @(negedge clk);
    #1;
    // R1 R10: reset state
    chk(req_ready === 1'b1 && rsp_valid === 1'b0, "R1 reset", {req_ready, rsp_valid}, 2'b10);
    chk(status === 8'h00 && cmd_done === 1'b0, "R10 reset status", status, 0);
    rst_n = 1;
    st_busy = 1; st_wen = 1; st_wake_n = 1;
    chk_status("R10 live bits");
    st_busy = 0; st_wake_n = 0;

    // R2 R3: length 5 block at scattered offsets, then padding
    wr(16'hFE00, 8'd5); wr(16'hFE11, 8'hA1); wr(16'hFE3F, 8'hA2);
    wr(16'hFE05, 8'hA3); wr(16'hFE00, 8'hA4);
    for (int i = 0; i < 4; i++) wr(16'hFE00, 8'hFF);
    repeat (2) @(negedge clk);
    chk(seen_done == 1, "R3 done pulses", seen_done, 1);
    for (int i = 0; i < 5; i++) chk_cmd(i, "R2 cmd store");
    chk_cmd(5, "R3 padding dropped");

    // R9 R6: short response, read past end
    load_resp(4, 1, 1);
    chk_status("R9 commit flags");
    for (int i = 0; i < 6; i++) rd_chk(16'hFE00, "R6 read/fill");
    chk_status("R7 read keeps status");

    // R7: read reopened the command buffer
    wr(16'hFE00, 8'd3);
    chk_cmd(0, "R7 cmd restart at 0");
    // R5: command write rewinds response pointer
    rd_chk(16'hFE00, "R5 pre"); rd_chk(16'hFE00, "R5 pre");
    wr(16'hFE01, 8'h77);
    rd_chk(16'hFE00, "R5 rewound");

    // R8: reset window with data, flags all set
    rd_chk(16'hFE00, "R8 pre");
    wr(16'hFFE7, 8'h5A);
    chk_status("R8 crce only cleared");
    rd_chk(16'hFE00, "R8 rsp kept");
    wr(16'hFFFF, 8'h00);
    wr(16'hFE00, 8'h42);
    chk_cmd(0, "R8 cmd ptr zero");

    // R4: oversize block saturates
    wr(16'hFFE0, 8'h00);
    wr(16'hFE00, 8'd200);
    for (int i = 1; i < 70; i++) wr(16'hFE00, 8'(i + 8'h10));
    chk_cmd(63, "R4 last slot");
    repeat (2) @(negedge clk);
    chk(seen_done == exp_done, "R4 no done", seen_done, exp_done);

    // R11: stray addresses
    wr(16'hFFE0, 8'h00);
    wr(16'hFE00, 8'd4); wr(16'hFE00, 8'h91);
    wr(16'h1234, 8'h33);
    wr(16'hFE00, 8'h92);
    chk_cmd(1, "R11 stray write ignored");
    chk_cmd(2, "R11 stray write ignored");
    rd_chk(16'h1234, "R11 stray read fill");
    rd_chk(16'hFFE3, "R11 rst window read fill");
    chk_status("R11 status kept");

    // R1: back-pressure with a waiting second read
    wr(16'hFFE0, 8'h00);
    load_resp(8, 0, 0);
    e1 = model_read(16'hFE00);
    e2 = model_read(16'hFE00);
    @(negedge clk);
    rsp_ready = 0; req_valid = 1; req_we = 0; req_addr = 16'hFE00;
    @(negedge clk);
    x = rsp_data;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk(rsp_valid === 1'b1 && req_ready === 1'b0 && rsp_data === e1,
          "R1 hold", rsp_data, e1);
      @(negedge clk);
    end
    rsp_ready = 1;
    @(negedge clk);
    req_valid = 0;
    chk(rsp_valid === 1'b1 && rsp_data === e2, "R1 second accepted", rsp_data, e2);
    rd_chk(16'hFE00, "R1 next after stall");

    // random mix
    for (int n = 0; n < 400; n++) begin
      int k = int'($urandom_range(0, 99));
      if (k < 40) wr(16'hFE00 + 16'($urandom_range(0, 63)),
                     (m_cptr == 0) ? 8'($urandom_range(1, 12)) : 8'($urandom));
      else if (k < 75) rd_chk(16'hFE00 + 16'($urandom_range(0, 63)), "R6 random read");
      else if (k < 83) wr(16'hFFE0 + 16'($urandom_range(0, 31)), 8'($urandom));
      else if (k < 90) rd_chk(16'($urandom_range(0, 16'hFDFF)), "R11 random stray");
      else if (k < 94) wr(16'($urandom_range(0, 16'hFDFF)), 8'($urandom));
      else load_resp(int'($urandom_range(0, 70)), 1'($urandom), 1'($urandom));
      if (n % 50 == 49) chk_status("R9 random status");
    end
    repeat (2) @(negedge clk);
    chk(seen_done == exp_done, "R3 random done count", seen_done, exp_done);
    for (int i = 0; i < m_cptr; i++) chk_cmd(i, "R2 random cmd");
    summary();
  end
endmodule